// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block decides when a small microcontroller core leaves its stop (lowest-power) state. Software first programs an 8-bit recovery configuration register. The register chooses one wake source, a wake polarity, and whether recovery runs through a long reset hold-off or wakes at once. It also holds the clock divide-by-16 select that the clocking logic reads. A stop request then parks the controller in the stop state. While it is parked, the controller watches the selected port pin, or the NOR of a pin group, through a synchronizer.

A wake ends the stop state. It can come from the selected pin event, from an external wake line driven by a second recovery register, or from a watchdog event. On a wake, the block emits a one-cycle wake pulse and clears the divide-by-16 select. If the hold-off is enabled, it then keeps a reset-delay signal high for a programmable number of cycles. In fast mode the hold-off is skipped, but a pin or external-line event must persist before it is accepted. A read-only flag records whether the last recovery was warm (out of stop) or cold.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, reg_rdata_o reads 0x20 (hold-off enabled, polarity low, source 000, divide select 0, flag 0), and stop_o, wake_o and rst_dly_o are all low.
- R2: A register write outside the stop state loads bit 6 (polarity), bit 5 (hold-off enable), bits 4:2 (source) and bit 0 (divide select). Bit 1 always reads 0. Written bit 7 is ignored, and bit 7 reads the warm flag.
- R3: A register write while stop_o is high leaves every register field unchanged.
- R4: stop_req_i in the run state enters the stop state at that edge, with stop_o high from the next cycle. It also sets the warm flag to 1.
- R5: Source codes 010, 011 and 100 select P3 pins p3_pin_i[0], [1] and [2]. Code 101 selects p2_pin_i[7]. Codes 000 and 001 never wake from pins.
- R6: Source code 110 uses the NOR of p2_pin_i[3:0], and code 111 uses the NOR of p2_pin_i[7:0].
- R7: With polarity 1, the selected source wakes when it is high. With polarity 0, it wakes when it is low.
- R8: A selected P3 pin whose p3_an_i bit is set never wakes. A selected p2 pin whose p2_oe_i bit is set never wakes. A p2 pin with p2_oe_i set counts as low inside the NOR.
- R9: Pins pass through two synchronizer flops, so wake_o pulses for one cycle three clock edges after a qualifying pin change. With hold-off enabled, rst_dly_o is high for exactly DLY_CYC cycles starting in the same cycle as wake_o, then drops.
- R10: With hold-off disabled, the synchronized wake condition must be true on 5 consecutive edges in the stop state. The wake is taken on the fifth edge, a shorter run is discarded, and rst_dly_o stays low.
- R11: Every recovery clears the divide select (bit 0) at the same edge that raises wake_o.
- R12: aux_wake_i is ORed with the selected pin event without synchronization. In fast mode it is subject to the same 5-edge qualification.
- R13: wdt_rst_i in the stop state wakes at the next edge without qualification, and the warm flag stays 1. Outside the stop state it clears the flag and blocks a stop request in the same cycle.
- R14: A register write and a stop request in the same run-state cycle both take effect: the fields are written and the stop state is entered with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, bit 7 is the warm flag |
| stop_req_i | input | 1 | Request to enter stop state |
| p2_pin_i | input | P2_W | Port 2 pin levels (asynchronous) |
| p2_oe_i | input | P2_W | Port 2 pin configured as output |
| p3_pin_i | input | P3_W | Port 3 pins 1..3 levels (asynchronous) |
| p3_an_i | input | P3_W | Port 3 pin configured as analog input |
| aux_wake_i | input | 1 | Wake request from second recovery register |
| wdt_rst_i | input | 1 | Watchdog event |
| stop_o | output | 1 | Stop state active |
| wake_o | output | 1 | One-cycle recovery pulse |
| rst_dly_o | output | 1 | Post-wake reset hold-off active |
| warm_o | output | 1 | Warm/cold start flag |

## Verification
A register write can land in the same cycle as a stop request. The bench pulses reg_we_i and stop_req_i together from the run state. It then judges the result by reading back a register holding the written fields with bit 7 set, while stop_o is high. The divide-select clear on recovery also meets the write blocking in stop. A wake edge is the only edge that can modify bit 0 while stopped, so the readback taken in the wake_o cycle must show bit 0 cleared and the other fields untouched. A watchdog event can likewise coincide with a stop request in the run state. In that case the clear of the warm flag takes priority and the stop entry is blocked.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    SRC_RESET   = 3'b000,
    SRC_RSVD    = 3'b001,
    SRC_P31     = 3'b010,
    SRC_P32     = 3'b011,
    SRC_P33     = 3'b100,
    SRC_P27     = 3'b101,
    SRC_NOR_LO  = 3'b110,
    SRC_NOR_ALL = 3'b111
  } wake_src_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_DELAY = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic      pol;
    logic      dly_en;
    wake_src_e src;
    logic      div16;
  } cfg_t;

  localparam cfg_t CFG_RST = '{pol: 1'b0, dly_en: 1'b1, src: SRC_RESET, div16: 1'b0};
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/swc_src_sel.sv
module swc_src_sel
  import swc_pkg::*;
#(
  parameter int unsigned P2_W     = 8,
  parameter int unsigned P3_W     = 3,
  parameter int unsigned NOR_LO_W = 4
) (
  input  logic [P2_W-1:0] p2_i,
  input  logic [P2_W-1:0] p2_oe_i,
  input  logic [P3_W-1:0] p3_i,
  input  logic [P3_W-1:0] p3_an_i,
  input  wake_src_e       src_i,
  input  logic            pol_i,
  output logic            evt_o
);
  localparam logic [P2_W-1:0] LO_MASK  = {{(P2_W-NOR_LO_W){1'b0}}, {NOR_LO_W{1'b1}}};
  localparam int unsigned     TOP_P2   = P2_W - 1;

  logic [P2_W-1:0] p2_eff;
  logic            nor_lo, nor_all;
  logic            lvl, blocked;

  // output-configured pins read as 0 so the rest decide the NOR
  assign p2_eff  = p2_i & ~p2_oe_i;
  assign nor_lo  = ~|(p2_eff & LO_MASK);
  assign nor_all = ~|p2_eff;

  always_comb begin
    lvl     = 1'b0;
    blocked = 1'b1;
    unique case (src_i)
      SRC_P31:     begin lvl = p3_i[0];      blocked = p3_an_i[0];      end
      SRC_P32:     begin lvl = p3_i[1];      blocked = p3_an_i[1];      end
      SRC_P33:     begin lvl = p3_i[2];      blocked = p3_an_i[2];      end
      SRC_P27:     begin lvl = p2_i[TOP_P2]; blocked = p2_oe_i[TOP_P2]; end
      SRC_NOR_LO:  begin lvl = nor_lo;       blocked = 1'b0;            end
      SRC_NOR_ALL: begin lvl = nor_all;      blocked = 1'b0;            end
      default:     begin lvl = 1'b0;         blocked = 1'b1;            end
    endcase
  end

  assign evt_o = !blocked && (lvl == pol_i);
endmodule

// File: rtl/swc_seq.sv
module swc_seq
  import swc_pkg::*;
#(
  parameter int unsigned DLY_CYC  = 1000000,
  parameter int unsigned QUAL_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic src_evt_i,
  input  logic aux_i,
  input  logic wdt_i,
  input  logic dly_en_i,
  output logic enter_o,
  output logic recover_o,
  output logic stop_o,
  output logic rst_dly_o,
  output logic wake_o
);
  localparam int unsigned DW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [DW-1:0] DLY_LAST  = DW'(DLY_CYC - 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYC - 1);

  seq_state_e      state_q, state_d;
  logic [DW-1:0]   dly_cnt_q;
  logic [QW-1:0]   qual_cnt_q;
  logic            wake_q;
  logic            cond, qualified, hit;

  assign cond      = src_evt_i | aux_i;
  assign qualified = dly_en_i ? cond : (cond && (qual_cnt_q == QUAL_LAST));
  assign hit       = wdt_i | qualified;

  assign enter_o   = (state_q == ST_RUN) && stop_req_i && !wdt_i;
  assign recover_o = (state_q == ST_STOP) && hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (enter_o) state_d = ST_STOP;
      ST_STOP:  if (recover_o) state_d = dly_en_i ? ST_DELAY : ST_RUN;
      ST_DELAY: if (dly_cnt_q == '0) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= recover_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 dly_cnt_q <= '0;
    else if (recover_o)                          dly_cnt_q <= DLY_LAST;
    else if (state_q == ST_DELAY && dly_cnt_q != '0) dly_cnt_q <= dly_cnt_q - 1'b1;
  end

  // fast-wake persistence counter, saturating, cleared when condition drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   qual_cnt_q <= '0;
    else if (state_q != ST_STOP || !cond)          qual_cnt_q <= '0;
    else if (qual_cnt_q != QUAL_LAST)              qual_cnt_q <= qual_cnt_q + 1'b1;
  end

  assign stop_o    = (state_q == ST_STOP);
  assign rst_dly_o = (state_q == ST_DELAY);
  assign wake_o    = wake_q;

  // R9
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R9
  dly_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_dly_o |-> (dly_cnt_q <= DLY_LAST));

  // R10
  qual_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !dly_en_i && !wdt_i && qual_cnt_q < QUAL_LAST) |=> stop_o);

  // R4
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_o && !rst_dly_o && stop_req_i && !wdt_i) |=> stop_o);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned P2_W        = 8,
  parameter int unsigned P3_W        = 3,
  parameter int unsigned NOR_LO_W    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_CYC     = 1000000,
  parameter int unsigned QUAL_CYC    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            stop_req_i,
  input  logic [P2_W-1:0] p2_pin_i,
  input  logic [P2_W-1:0] p2_oe_i,
  input  logic [P3_W-1:0] p3_pin_i,
  input  logic [P3_W-1:0] p3_an_i,
  input  logic            aux_wake_i,
  input  logic            wdt_rst_i,
  output logic            stop_o,
  output logic            wake_o,
  output logic            rst_dly_o,
  output logic            warm_o
);
  localparam int unsigned PW = P2_W + P3_W;

  cfg_t            cfg_q;
  logic            warm_q;
  logic [PW-1:0]   pin_s;
  logic [P2_W-1:0] p2_s;
  logic [P3_W-1:0] p3_s;
  logic            src_evt, enter, recover;
  logic            unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[7], reg_wdata_i[1]};

  swc_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({p2_pin_i, p3_pin_i}),
    .q_o    (pin_s)
  );

  assign p2_s = pin_s[PW-1:P3_W];
  assign p3_s = pin_s[P3_W-1:0];

  swc_src_sel #(.P2_W(P2_W), .P3_W(P3_W), .NOR_LO_W(NOR_LO_W)) u_src_sel (
    .p2_i    (p2_s),
    .p2_oe_i (p2_oe_i),
    .p3_i    (p3_s),
    .p3_an_i (p3_an_i),
    .src_i   (cfg_q.src),
    .pol_i   (cfg_q.pol),
    .evt_o   (src_evt)
  );

  swc_seq #(.DLY_CYC(DLY_CYC), .QUAL_CYC(QUAL_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .src_evt_i  (src_evt),
    .aux_i      (aux_wake_i),
    .wdt_i      (wdt_rst_i),
    .dly_en_i   (cfg_q.dly_en),
    .enter_o    (enter),
    .recover_o  (recover),
    .stop_o     (stop_o),
    .rst_dly_o  (rst_dly_o),
    .wake_o     (wake_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (recover) begin
      cfg_q.div16 <= 1'b0;
    end else if (reg_we_i && !stop_o) begin
      cfg_q.pol    <= reg_wdata_i[6];
      cfg_q.dly_en <= reg_wdata_i[5];
      cfg_q.src    <= wake_src_e'(reg_wdata_i[4:2]);
      cfg_q.div16  <= reg_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  warm_q <= 1'b0;
    else if (wdt_rst_i && !stop_o) warm_q <= 1'b0;
    else if (enter)               warm_q <= 1'b1;
  end

  assign warm_o      = warm_q;
  assign reg_rdata_o = {warm_q, cfg_q.pol, cfg_q.dly_en, cfg_q.src, 1'b0, cfg_q.div16};

  // R3
  stop_wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && reg_we_i) |=> ($stable(cfg_q.src) && $stable(cfg_q.pol) && $stable(cfg_q.dly_en)));

  // R11
  div_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !reg_rdata_o[0]);

  // R4
  warm_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> warm_o);

  // R9
  delay_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && cfg_q.dly_en) |-> rst_dly_o);
endmodule

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;
  localparam int unsigned DLY = 16;
  localparam int unsigned NV  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       stop_req = 1'b0;
  logic [7:0] p2_pin = '0, p2_oe = '0;
  logic [2:0] p3_pin = '0, p3_an = '0;
  logic       aux_wake = 1'b0, wdt_rst = 1'b0;
  logic       stop_s, wake_s, rst_dly_s, warm_s;

  int n_chk = 0, n_bad = 0, cyc = 0, wake_cnt = 0;

  always #2.5 clk = ~clk;

  stop_wake_ctrl #(.DLY_CYC(DLY)) u_stop_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .stop_req_i(stop_req), .p2_pin_i(p2_pin),
    .p2_oe_i(p2_oe), .p3_pin_i(p3_pin), .p3_an_i(p3_an), .aux_wake_i(aux_wake),
    .wdt_rst_i(wdt_rst), .stop_o(stop_s), .wake_o(wake_s), .rst_dly_o(rst_dly_s),
    .warm_o(warm_s)
  );

  // {src[2:0], pol, p2[7:0], p2_oe[7:0], p3[2:0], p3_an[2:0], expect_wake}
  localparam logic [26:0] VEC [NV] = '{
    {3'b010, 1'b1, 8'h00, 8'h00, 3'b001, 3'b000, 1'b1}, // R5 R7 P31 high
    {3'b010, 1'b1, 8'h00, 8'h00, 3'b001, 3'b001, 1'b0}, // R8 analog P31
    {3'b011, 1'b0, 8'h00, 8'h00, 3'b101, 3'b000, 1'b1}, // R7 P32 low
    {3'b011, 1'b1, 8'h00, 8'h00, 3'b101, 3'b000, 1'b0}, // R7 P32 not high
    {3'b100, 1'b1, 8'h00, 8'h00, 3'b100, 3'b000, 1'b1}, // R5 P33
    {3'b101, 1'b1, 8'h80, 8'h00, 3'b000, 3'b000, 1'b1}, // R5 P27
    {3'b101, 1'b1, 8'h80, 8'h80, 3'b000, 3'b000, 1'b0}, // R8 P27 output
    {3'b110, 1'b1, 8'hF0, 8'h00, 3'b000, 3'b000, 1'b1}, // R6 low nibble NOR
    {3'b110, 1'b1, 8'h01, 8'h00, 3'b000, 3'b000, 1'b0}, // R6
    {3'b110, 1'b1, 8'h01, 8'h01, 3'b000, 3'b000, 1'b1}, // R8 masked in NOR
    {3'b111, 1'b1, 8'hF0, 8'h00, 3'b000, 3'b000, 1'b0}, // R6 full NOR
    {3'b111, 1'b0, 8'h10, 8'h00, 3'b000, 3'b000, 1'b1}, // R6 R7 low NOR
    {3'b000, 1'b0, 8'h00, 8'h00, 3'b000, 3'b000, 1'b0}, // R5 reset-only
    {3'b001, 1'b1, 8'h00, 8'h00, 3'b111, 3'b000, 1'b0}, // R5 reserved
    {3'b111, 1'b1, 8'h00, 8'h00, 3'b000, 3'b000, 1'b1}, // R6
    {3'b100, 1'b0, 8'h00, 8'h00, 3'b011, 3'b100, 1'b0}  // R8 analog P33 low
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d cycles expected<20000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) if (wake_s) wake_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v; step(1); reg_we = 1'b0;
  endtask

  task automatic enter_stop();
    stop_req = 1'b1; step(1); stop_req = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1 rdata", reg_rdata, 8'h20);
    chk("R1 outs", {stop_s, wake_s, rst_dly_s, warm_s}, 4'b0000);

    // R2
    wr(8'hFF);
    chk("R2 write", reg_rdata, 8'h7D);

    // R14 write and stop request together
    reg_we = 1'b1; reg_wdata = 8'h45; stop_req = 1'b1;
    step(1);
    reg_we = 1'b0; stop_req = 1'b0;
    chk("R14 rdata", reg_rdata, 8'hC5);
    chk("R14 R4 stop", {stop_s, warm_s}, 2'b11);

    // R3
    wr(8'h00);
    chk("R3 hold", reg_rdata, 8'hC5);

    // R12 R10 aux in fast mode: 4-edge run discarded, 5-edge accepted
    wake_cnt = 0;
    aux_wake = 1'b1; step(4); aux_wake = 1'b0;
    chk("R10 short run", {wake_cnt[0], stop_s}, 2'b01);
    step(1);
    aux_wake = 1'b1; step(4);
    chk("R12 before fifth", wake_s, 1'b0);
    step(1);
    aux_wake = 1'b0;
    chk("R12 wake", {wake_s, rst_dly_s, stop_s}, 3'b100);
    chk("R11 div cleared", reg_rdata, 8'hC4);

    // R13 watchdog outside stop clears flag, blocks stop entry
    wdt_rst = 1'b1; stop_req = 1'b1; step(1); wdt_rst = 1'b0; stop_req = 1'b0;
    chk("R13 cold", {reg_rdata, stop_s}, {8'h44, 1'b0});

    // R5..R8 vector table, hold-off enabled
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      p2_pin = v[22:15]; p2_oe = v[14:7]; p3_pin = v[6:4]; p3_an = v[3:1];
      wr({1'b0, v[23], 1'b1, v[26:24], 2'b00});
      step(3);
      wake_cnt = 0;
      enter_stop();
      step(5);
      chk($sformatf("R5-8 vec%0d", i), (wake_cnt != 0), v[0]);
      if (!v[0]) begin
        aux_wake = 1'b1; step(1); aux_wake = 1'b0;
      end
      step(DLY + 4);
      chk($sformatf("R9 recover vec%0d", i), {stop_s, rst_dly_s}, 2'b00);
    end

    // R9 delay timing with P31 pin
    p2_pin = '0; p2_oe = '0; p3_pin = '0; p3_an = '0;
    wr(8'h68);
    step(3);
    enter_stop();
    p3_pin = 3'b001;
    step(2);
    chk("R9 sync latency", wake_s, 1'b0);
    step(1);
    chk("R9 wake+delay", {wake_s, rst_dly_s}, 2'b11);
    step(DLY - 1);
    chk("R9 delay held", rst_dly_s, 1'b1);
    step(1);
    chk("R9 delay released", {rst_dly_s, stop_s}, 2'b00);

    // R10 fast wake from pin
    p3_pin = '0;
    wr(8'h48);
    step(3);
    enter_stop();
    p3_pin = 3'b001;
    step(6);
    chk("R10 not yet", {wake_s, stop_s}, 2'b01);
    step(1);
    chk("R10 fast wake", {wake_s, rst_dly_s, stop_s}, 3'b100);
    p3_pin = '0;

    // R13 watchdog inside stop
    wr(8'h44);
    step(3);
    enter_stop();
    wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
    chk("R13 wdt wake", {wake_s, stop_s, reg_rdata}, {2'b10, 8'hC4});

    step(2);
    summary();
    $finish;
  end
endmodule